// File: doc/BRIEF.md
# Debug Command Decoder Engine

This block is the command front end of an in-circuit debug engine. A host serial link delivers one byte at a time as a data byte plus a valid strobe. While the engine is in debug mode and not already gathering operands, each byte is taken as an op code. Commands that carry operands then gather four more bytes. These fill a 16-bit address register and a 16-bit data/count register, which the service code in ROM reads.

When a service command is complete, the engine writes a 4-bit command field and raises a one-cycle request for the CPU to jump to a fixed service vector. Two further op codes control the debug state itself. Single-step leaves debug mode, lets the CPU run exactly one cycle, and then comes back. Resume leaves debug mode for background mode. A break request input takes the engine from background mode into debug mode. The serial physical layer, the ROM routine, memory access and the CPU core are all outside this block.

Top module: `dbg_cmd_engine`

## Requirements
- R1: While `rst_n` is low at a clock edge, the address register, the data/count register and the command field clear to zero, the operand counter clears, the engine goes to background mode (`in_debug` low), and no pulse output is high.
- R2: In background mode, `brk_req` high at an edge puts the engine in debug mode. `in_debug` and a one-cycle `entry_pulse` appear after that edge.
- R3: Bytes presented with `rx_valid` in background mode, or during a single-step sequence, have no effect. Bytes with `rx_valid` low have no effect in any mode.
- R4: Op code 0x21 (register map dump) takes no operands. The edge that accepts it sets `cmd_field` to 4'b0001 and raises `jump_req` for one cycle, with `jump_vec` equal to 16'h8010.
- R5: Op codes 0x22, 0x23, 0x24 and 0x25 each complete on the edge that accepts their fourth operand byte. That edge sets `cmd_field` to the op code's low nibble (2, 3, 4 or 5) and raises `jump_req` for one cycle. There is no jump request before then.
- R6: Operand bytes fill the registers in this order: `addr_word[7:0]`, then `addr_word[15:8]`, then `data_word[7:0]`, then `data_word[15:8]`. Each byte lands on the edge that accepts it. Every address value, 16'hFFFF included, is passed on unchanged.
- R7: While operands are pending, every valid byte is an operand, even if its value equals an op code. For example, 0x27 taken as an operand does not leave debug mode.
- R8: Op code 0x20 and every byte outside 0x20 to 0x27 leave all registers and `cmd_field` unchanged and raise no `jump_req`.
- R9: Op code 0x26 (single step) produces, in the three cycles after its accepting edge, `exit_pulse` with `in_debug` low, then `cpu_step` with `in_debug` low, then `entry_pulse` with `in_debug` high. `cmd_field` does not change.
- R10: Op code 0x27 (resume) produces `exit_pulse` for one cycle after its accepting edge and leaves the engine in background mode. `cmd_field` does not change.
- R11: `exit_pulse`, `entry_pulse` and `cpu_step` last one cycle. Each `jump_req` follows exactly one accepted byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_byte | input | 8 | Byte from the host serial link |
| rx_valid | input | 1 | rx_byte is valid this cycle |
| brk_req | input | 1 | Request to enter debug mode from background |
| in_debug | output | 1 | Engine is in debug mode and waiting for bytes |
| entry_pulse | output | 1 | One-cycle strobe: debug mode entered |
| exit_pulse | output | 1 | One-cycle strobe: debug mode exited |
| cpu_step | output | 1 | One-cycle CPU execution enable during single step |
| jump_req | output | 1 | One-cycle request to jump to the service vector |
| jump_vec | output | 16 | Service vector address (16'h8010) |
| cmd_field | output | 4 | Command code for the service routine |
| addr_word | output | 16 | Gathered address operand |
| data_word | output | 16 | Gathered data or count operand |

## Verification
Every result is registered once. The command field, `jump_req`, the operand lanes and the first mode strobe are therefore visible in the cycle right after the edge that accepts the byte. The single-step sequence then moves one stage per cycle: stage 1 is the exit strobe, stage 2 is the step enable, and stage 3 is the entry strobe. The driver changes inputs and samples outputs on the falling edge. Each expectation is read at the first falling edge after the accepting edge, and at one falling edge per later stage. A monitor pops one queued jump record for each cycle that `jump_req` is high, so a late, extra or stretched request shows up as a mismatch.

// File: rtl/dbg_cmd_pkg.sv
// Package: shared types for the debug command engine.
// Assumes op codes are grouped under one upper nibble value.
package dbg_cmd_pkg;

    // Engine mode: background, debug, and the two single-step stages
    typedef enum logic [1:0] {
        MODE_BG    = 2'd0,
        MODE_DBG   = 2'd1,
        MODE_SEXIT = 2'd2,
        MODE_SRUN  = 2'd3
    } mode_t;

    // Action class of a decoded op code
    typedef enum logic [2:0] {
        ACT_NONE   = 3'd0,
        ACT_JUMP   = 3'd1,
        ACT_ARGS   = 3'd2,
        ACT_STEP   = 3'd3,
        ACT_RESUME = 3'd4
    } act_t;

    localparam logic [3:0] OP_GROUP = 4'h2;

endpackage

// File: rtl/dbg_op_decode.sv
// Module: combinational op code classifier.
// Maps an op byte to an action class and a command nibble.
// Assumes BYTE_W >= 8; the group sits in bits [7:4] and the code in [3:0].
module dbg_op_decode
    import dbg_cmd_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] op_byte,
    output act_t              op_act,
    output logic [3:0]        op_code
);

    logic in_group;

    // Group test: the byte must carry the debug op code group
    always_comb begin
        in_group = (op_byte[7:4] == OP_GROUP);
        if (BYTE_W > 8) begin
            in_group = in_group && (op_byte[BYTE_W-1:4] == (BYTE_W-4)'(OP_GROUP));
        end
    end

    // Classify the low nibble into an action (R8: anything else is no action)
    always_comb begin
        op_code = op_byte[3:0];
        op_act  = ACT_NONE;
        if (in_group) begin
            case (op_byte[3:0])
                4'h1:                   op_act = ACT_JUMP;
                4'h2, 4'h3, 4'h4, 4'h5: op_act = ACT_ARGS;
                4'h6:                   op_act = ACT_STEP;
                4'h7:                   op_act = ACT_RESUME;
                default:                op_act = ACT_NONE;
            endcase
        end
    end

endmodule

// File: rtl/dbg_arg_collect.sv
// Module: operand gatherer.
// After start, takes 2*WORD_W/BYTE_W bytes: address lanes low to high,
// then data lanes low to high. Lanes keep their value until overwritten.
// Assumes WORD_W is a multiple of BYTE_W.
module dbg_arg_collect #(
    parameter int BYTE_W = 8,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              take,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              pending,
    output logic              last,
    output logic [WORD_W-1:0] addr_word,
    output logic [WORD_W-1:0] data_word
);

    localparam int LANES     = WORD_W / BYTE_W;
    localparam int ARG_BYTES = 2 * LANES;
    localparam int CNT_W     = $clog2(ARG_BYTES + 1);

    logic [CNT_W-1:0]  left_q;
    logic [CNT_W-1:0]  lane_idx;
    logic [BYTE_W-1:0] lane_q [ARG_BYTES];

    assign pending  = (left_q != '0);
    assign last     = take && (left_q == CNT_W'(1));
    assign lane_idx = CNT_W'(ARG_BYTES) - left_q;

    // Remaining-operand counter: loaded on start, counts down per byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (start) begin
            left_q <= CNT_W'(ARG_BYTES);
        end else if (take && pending) begin
            left_q <= left_q - CNT_W'(1);
        end
    end

    // One byte lane per operand position, R6 ordering
    for (genvar g = 0; g < ARG_BYTES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_q[g] <= '0;
            end else if (take && pending && (lane_idx == CNT_W'(g))) begin
                lane_q[g] <= byte_in;
            end
        end
    end

    // Assemble the two words from their lanes
    for (genvar g = 0; g < LANES; g++) begin : g_word
        assign addr_word[g*BYTE_W +: BYTE_W] = lane_q[g];
        assign data_word[g*BYTE_W +: BYTE_W] = lane_q[LANES + g];
    end

    // R5
    // no_overcount_chk
    no_overcount_chk: assert property (@(posedge clk) disable iff (!rst_n)
        left_q <= CNT_W'(ARG_BYTES));

endmodule

// File: rtl/dbg_mode_fsm.sv
// Module: debug mode controller.
// Tracks background/debug mode, runs the single-step sequence
// (exit, one CPU cycle, entry) and drives registered one-cycle strobes.
// Assumes do_step and do_resume are raised only while in debug mode.
module dbg_mode_fsm
    import dbg_cmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic brk_req,
    input  logic do_step,
    input  logic do_resume,
    output logic in_debug,
    output logic entry_pulse,
    output logic exit_pulse,
    output logic cpu_step
);

    mode_t mode_q, mode_d;

    assign in_debug = (mode_q == MODE_DBG);

    // Next-mode selection
    always_comb begin
        mode_d = mode_q;
        case (mode_q)
            MODE_BG:    if (brk_req) mode_d = MODE_DBG;
            MODE_DBG:   if (do_step) mode_d = MODE_SEXIT;
                        else if (do_resume) mode_d = MODE_BG;
            MODE_SEXIT: mode_d = MODE_SRUN;
            MODE_SRUN:  mode_d = MODE_DBG;
            default:    mode_d = MODE_BG;
        endcase
    end

    // Mode register and strobes, all registered together
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q      <= MODE_BG;
            entry_pulse <= 1'b0;
            exit_pulse  <= 1'b0;
            cpu_step    <= 1'b0;
        end else begin
            mode_q      <= mode_d;
            entry_pulse <= (mode_q == MODE_BG && brk_req) || (mode_q == MODE_SRUN);
            exit_pulse  <= (mode_q == MODE_DBG) && (do_step || do_resume);
            cpu_step    <= (mode_q == MODE_SEXIT);
        end
    end

    // R9
    // step_after_exit_chk
    step_after_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_step |-> $past(exit_pulse));

    // R9
    // entry_in_debug_chk
    entry_in_debug_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entry_pulse |-> in_debug);

    // R11
    // exit_single_chk
    exit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exit_pulse |=> !exit_pulse);

    // R10
    // exit_leaves_debug_chk
    exit_leaves_debug_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exit_pulse |-> !in_debug);

endmodule

// File: rtl/dbg_cmd_engine.sv
// Module: debug command engine top.
// Accepts op codes only in debug mode with no operands pending, gathers
// operands, writes the command field and requests the service vector jump.
// Assumes the host presents at most one byte per cycle.
module dbg_cmd_engine
    import dbg_cmd_pkg::*;
#(
    parameter int               BYTE_W  = 8,
    parameter int               WORD_W  = 16,
    parameter logic [WORD_W-1:0] SVC_VEC = 16'h8010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_valid,
    input  logic              brk_req,
    output logic              in_debug,
    output logic              entry_pulse,
    output logic              exit_pulse,
    output logic              cpu_step,
    output logic              jump_req,
    output logic [WORD_W-1:0] jump_vec,
    output logic [3:0]        cmd_field,
    output logic [WORD_W-1:0] addr_word,
    output logic [WORD_W-1:0] data_word
);

    act_t       op_act;
    logic [3:0] op_code;
    logic       pending, last;
    logic       op_take, arg_take, start_args;
    logic [3:0] held_code_q;
    logic [3:0] cmd_q;
    logic       jump_q;

    assign jump_vec  = SVC_VEC;
    assign cmd_field = cmd_q;
    assign jump_req  = jump_q;

    assign op_take    = rx_valid && in_debug && !pending;
    assign arg_take   = rx_valid && in_debug && pending;
    assign start_args = op_take && (op_act == ACT_ARGS);

    dbg_op_decode #(.BYTE_W(BYTE_W)) u_decode (
        .op_byte (rx_byte),
        .op_act  (op_act),
        .op_code (op_code)
    );

    dbg_arg_collect #(.BYTE_W(BYTE_W), .WORD_W(WORD_W)) u_args (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_args),
        .take      (arg_take),
        .byte_in   (rx_byte),
        .pending   (pending),
        .last      (last),
        .addr_word (addr_word),
        .data_word (data_word)
    );

    dbg_mode_fsm u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .brk_req     (brk_req),
        .do_step     (op_take && (op_act == ACT_STEP)),
        .do_resume   (op_take && (op_act == ACT_RESUME)),
        .in_debug    (in_debug),
        .entry_pulse (entry_pulse),
        .exit_pulse  (exit_pulse),
        .cpu_step    (cpu_step)
    );

    // Hold the op code nibble of an operand command until it completes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_code_q <= '0;
        end else if (start_args) begin
            held_code_q <= op_code;
        end
    end

    // Command field and service jump request (R4, R5)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            jump_q <= 1'b0;
        end else begin
            jump_q <= 1'b0;
            if (op_take && (op_act == ACT_JUMP)) begin
                cmd_q  <= op_code;
                jump_q <= 1'b1;
            end else if (last) begin
                cmd_q  <= held_code_q;
                jump_q <= 1'b1;
            end
        end
    end

    // R11
    // jump_after_byte_chk
    jump_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        jump_req |-> $past(rx_valid));

    // R3
    // jump_in_debug_chk
    jump_in_debug_chk: assert property (@(posedge clk) disable iff (!rst_n)
        jump_req |-> in_debug);

    // R7
    // pending_in_debug_chk
    pending_in_debug_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> in_debug);

endmodule

// File: tb/test_dbg_cmd_engine.sv
// Bench: scoreboard for dbg_cmd_engine. The driver queues the expected
// jump records and a falling-edge monitor pops them on each jump_req.
module test_dbg_cmd_engine;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [3:0]  cmd;
        logic [15:0] addr;
        logic [15:0] data;
    } jexp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_valid = 1'b0;
    logic        brk_req = 1'b0;
    logic        in_debug, entry_pulse, exit_pulse, cpu_step, jump_req;
    logic [15:0] jump_vec, addr_word, data_word;
    logic [3:0]  cmd_field;

    int    checks = 0;
    int    errors = 0;
    jexp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_cmd_engine i_dbg_cmd_engine (
        .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .brk_req(brk_req), .in_debug(in_debug), .entry_pulse(entry_pulse),
        .exit_pulse(exit_pulse), .cpu_step(cpu_step), .jump_req(jump_req),
        .jump_vec(jump_vec), .cmd_field(cmd_field), .addr_word(addr_word),
        .data_word(data_word)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one valid byte; returns at the falling edge after its accepting edge
    task automatic send(input logic [7:0] b);
        @(negedge clk);
        rx_byte  = b;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Operand command: queue the expected jump, then op code and four operands
    task automatic arg_cmd(input logic [7:0] op, input logic [15:0] a, input logic [15:0] d);
        send(op);
        send(a[7:0]);
        send(a[15:8]);
        chk("R6 addr after two operands", 32'(addr_word), 32'(a));
        send(d[7:0]);
        chk("R6 data low lane", 32'(data_word[7:0]), 32'(d[7:0]));
        chk("R5 no jump before fourth operand", 32'(jump_req), 32'd0);
        exp_q.push_back('{cmd: op[3:0], addr: a, data: d});
        send(d[15:8]);
        chk("R6 data after four operands", 32'(data_word), 32'(d));
        chk("R5 cmd_field", 32'(cmd_field), 32'(op[3:0]));
    endtask

    // Monitor: each cycle with jump_req must match one queued record
    always @(negedge clk) begin
        if (rst_n === 1'b1 && jump_req === 1'b1) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R8 unexpected jump actual cmd=%h expected none", cmd_field);
            end else begin
                jexp_t e;
                e = exp_q.pop_front();
                chk("R4 R5 jump cmd", 32'(cmd_field), 32'(e.cmd));
                chk("R4 jump vector", 32'(jump_vec), 32'h8010);
                chk("R6 jump addr", 32'(addr_word), 32'(e.addr));
                chk("R6 jump data", 32'(data_word), 32'(e.data));
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 addr", 32'(addr_word), 32'd0);
        chk("R1 data", 32'(data_word), 32'd0);
        chk("R1 cmd", 32'(cmd_field), 32'd0);
        chk("R1 background", 32'(in_debug), 32'd0);
        chk("R1 pulses", 32'({entry_pulse, exit_pulse, cpu_step, jump_req}), 32'd0);

        // R3: bytes ignored in background
        send(8'h21);
        send(8'h22);
        send(8'h34);
        chk("R3 cmd unchanged in background", 32'(cmd_field), 32'd0);
        chk("R3 addr unchanged in background", 32'(addr_word), 32'd0);

        // R2: break request enters debug
        @(negedge clk);
        brk_req = 1'b1;
        @(negedge clk);
        brk_req = 1'b0;
        chk("R2 in_debug", 32'(in_debug), 32'd1);
        chk("R2 entry_pulse", 32'(entry_pulse), 32'd1);
        @(negedge clk);
        chk("R11 entry_pulse one cycle", 32'(entry_pulse), 32'd0);

        // R3: valid low has no effect
        rx_byte = 8'h21;
        idle(4);
        chk("R3 valid low no cmd", 32'(cmd_field), 32'd0);

        // R4: register map dump
        exp_q.push_back('{cmd: 4'h1, addr: 16'h0, data: 16'h0});
        send(8'h21);
        chk("R4 cmd_field", 32'(cmd_field), 32'd1);

        // R5 R6: operand commands
        arg_cmd(8'h22, 16'h1234, 16'h5678);
        arg_cmd(8'h23, 16'h00A0, 16'h0003);
        // R6 R7: reserved address passes, op-code-valued operand stays data
        arg_cmd(8'h24, 16'hFFFF, 16'h2721);
        chk("R7 still in debug", 32'(in_debug), 32'd1);
        arg_cmd(8'h25, 16'h8000, 16'hBEEF);

        // R8: no-op and unknown op codes
        send(8'h20);
        send(8'h28);
        send(8'h31);
        send(8'hA5);
        send(8'h2F);
        chk("R8 cmd unchanged", 32'(cmd_field), 32'd5);
        chk("R8 addr unchanged", 32'(addr_word), 32'h8000);
        chk("R8 data unchanged", 32'(data_word), 32'hBEEF);
        chk("R8 operand counter idle", 32'(in_debug), 32'd1);
        // next byte still decoded as op code
        exp_q.push_back('{cmd: 4'h1, addr: 16'h8000, data: 16'hBEEF});
        send(8'h21);
        chk("R8 op code accepted after no-op", 32'(cmd_field), 32'd1);

        // R9: single step, with a byte offered mid-sequence (R3)
        @(negedge clk);
        rx_byte  = 8'h26;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_byte  = 8'h21;
        chk("R9 stage1 exit_pulse", 32'(exit_pulse), 32'd1);
        chk("R9 stage1 in_debug low", 32'(in_debug), 32'd0);
        chk("R9 stage1 no step", 32'(cpu_step), 32'd0);
        @(negedge clk);
        rx_valid = 1'b0;
        chk("R9 stage2 cpu_step", 32'(cpu_step), 32'd1);
        chk("R11 stage2 exit ended", 32'(exit_pulse), 32'd0);
        chk("R9 stage2 in_debug low", 32'(in_debug), 32'd0);
        @(negedge clk);
        chk("R9 stage3 entry_pulse", 32'(entry_pulse), 32'd1);
        chk("R9 stage3 in_debug", 32'(in_debug), 32'd1);
        chk("R11 stage3 step ended", 32'(cpu_step), 32'd0);
        @(negedge clk);
        chk("R11 entry ended", 32'(entry_pulse), 32'd0);
        chk("R9 cmd unchanged", 32'(cmd_field), 32'd1);

        // R10: resume
        send(8'h27);
        chk("R10 exit_pulse", 32'(exit_pulse), 32'd1);
        chk("R10 background", 32'(in_debug), 32'd0);
        @(negedge clk);
        chk("R11 exit one cycle", 32'(exit_pulse), 32'd0);
        chk("R10 cmd unchanged", 32'(cmd_field), 32'd1);
        send(8'h21);
        chk("R3 ignored after resume", 32'(in_debug), 32'd0);

        idle(4);
        chk("R5 all jumps seen", 32'(exp_q.size()), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule